// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside the fetch and status logic of a processor core. It takes the exception causes that can redirect execution: a reset request, an undefined-instruction trap, a supervisor call, an instruction-fetch abort, a data-access abort, and two level-sensitive interrupt lines (a normal one and a fast one). In each cycle it picks the most urgent cause that is allowed to act. For that cause it performs the full entry in a single clock.

The entry does four things. It emits a one-cycle flush pulse with the redirect address, taken from a fixed table of eight word-spaced slots. It forms the new status word: the mode field is replaced, the interrupt masks are raised, and all other bits are kept. It raises the save strobe of the banked register pair that belongs to the target mode. It presents the data for that pair: the interrupted PC for the return-address register and the old status word for the saved-status register.

The surrounding core owns the storage. It writes the banked pair when it sees the strobe, and it loads the new status word and PC when it sees the flush.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `flush` = 0, `bank_we` = 0, and `redirect_pc`, `new_status`, `link_data` and `saved_data` all zero.
- R2: A cause sampled at an edge where `flush` is low makes `flush` high for exactly the following cycle. No cause is accepted at an edge where `flush` is high, so a cause held steady produces flush pulses in alternate cycles (1,0,1).
- R3: When several causes are eligible at once, the winner is chosen in this order, from most to least urgent: reset, data abort, fast interrupt, normal interrupt, fetch abort, then undefined/supervisor call.
- R4: `redirect_pc` equals 4 × slot, with these slots: reset 0, undefined 1, supervisor call 2, fetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. This gives 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C.
- R5: The mode field `new_status[4:0]` and the one-hot `bank_we` bit depend on the cause:
  - reset or supervisor call: mode 5'b10011, bank 0
  - either abort: mode 5'b10111, bank 1
  - undefined: mode 5'b11011, bank 2
  - normal interrupt: mode 5'b10010, bank 3
  - fast interrupt: mode 5'b10001, bank 4
- R6: During the flush cycle, `link_data` equals the `cur_pc` sampled at the accepting edge, and `saved_data` equals the `cur_status` sampled at that edge.
- R7: Every entry sets `new_status[7]` (the normal-interrupt mask). Only reset and fast-interrupt entries also set `new_status[6]` (the fast-interrupt mask). All other bits outside [4:0] are copied from `cur_status`.
- R8: `irq_lvl` is ignored while `cur_status[7]` is 1. If the line is still high once that bit reads 0, the interrupt is taken.
- R9: `fiq_lvl` is ignored while `cur_status[6]` is 1. In that case a simultaneous, unmasked `irq_lvl` is taken instead.
- R10: If the undefined and supervisor-call causes are both high, the undefined entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction trap |
| req_svc | input | 1 | Supervisor call trap |
| req_pabt | input | 1 | Instruction-fetch abort |
| req_dabt | input | 1 | Data-access abort |
| irq_lvl | input | 1 | Normal interrupt, level-sensitive |
| fiq_lvl | input | 1 | Fast interrupt, level-sensitive |
| cur_status | input | STATUS_W | Current status word |
| cur_pc | input | ADDR_W | PC of the instruction being interrupted |
| flush | output | 1 | One-cycle pipeline flush / redirect pulse |
| redirect_pc | output | ADDR_W | Vector address to fetch from |
| new_status | output | STATUS_W | Status word to load on flush |
| bank_we | output | 5 | One-hot save strobe for the target mode's banked pair |
| link_data | output | ADDR_W | Return PC to write into the banked link register |
| saved_data | output | STATUS_W | Old status to write into the banked saved-status register |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and status, the interrupt masks at bits 7 and 6, and a 4-byte vector spacing. With these values, every vector from 0x00 to 0x1C can be observed, and so can the preservation of high status bits above the mode field. The bench plays the status register itself, writing back `new_status` after an interrupt entry. This lets it show a level-held interrupt being ignored while masked and then taken once the mask drops.

// File: rtl/exc_pkg.sv
// Shared types and cause-to-target mapping for the exception entry controller.
// Assumes a 5-bit mode field at the bottom of the status word.
package exc_pkg;

    typedef enum logic [2:0] {
        EXC_NONE,
        EXC_RESET,
        EXC_UNDEF,
        EXC_SVC,
        EXC_PABT,
        EXC_DABT,
        EXC_IRQ,
        EXC_FIQ
    } exc_kind_e;

    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 5;
    localparam int BANK_IW   = $clog2(NUM_BANKS);

    // Mode field written on entry for each cause.
    function automatic logic [MODE_W-1:0] mode_code(exc_kind_e k);
        case (k)
            EXC_RESET, EXC_SVC:  return 5'b10011;
            EXC_PABT, EXC_DABT:  return 5'b10111;
            EXC_UNDEF:           return 5'b11011;
            EXC_IRQ:             return 5'b10010;
            EXC_FIQ:             return 5'b10001;
            default:             return 5'b10000;
        endcase
    endfunction

    // Banked register pair index for each cause.
    function automatic logic [BANK_IW-1:0] bank_idx(exc_kind_e k);
        case (k)
            EXC_PABT, EXC_DABT:  return 3'd1;
            EXC_UNDEF:           return 3'd2;
            EXC_IRQ:             return 3'd3;
            EXC_FIQ:             return 3'd4;
            default:             return 3'd0;
        endcase
    endfunction

    // Vector table slot (word index) for each cause.
    function automatic logic [2:0] vec_slot(exc_kind_e k);
        case (k)
            EXC_UNDEF:  return 3'd1;
            EXC_SVC:    return 3'd2;
            EXC_PABT:   return 3'd3;
            EXC_DABT:   return 3'd4;
            EXC_IRQ:    return 3'd6;
            EXC_FIQ:    return 3'd7;
            default:    return 3'd0;
        endcase
    endfunction

    // Whether the entry also raises the fast-interrupt mask.
    function automatic logic sets_fast_mask(exc_kind_e k);
        return (k == EXC_RESET) || (k == EXC_FIQ);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Fixed-priority selection of the exception cause to act on this cycle.
// Assumes the interrupt lines are already qualified by their mask bits.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      req_reset,
    input  logic      req_undef,
    input  logic      req_svc,
    input  logic      req_pabt,
    input  logic      req_dabt,
    input  logic      irq_ok,
    input  logic      fiq_ok,
    output exc_kind_e kind
);

    // Priority chain: reset, data abort, fast irq, irq, fetch abort, undef, svc.
    always_comb begin
        if (req_reset)      kind = EXC_RESET;
        else if (req_dabt)  kind = EXC_DABT;
        else if (fiq_ok)    kind = EXC_FIQ;
        else if (irq_ok)    kind = EXC_IRQ;
        else if (req_pabt)  kind = EXC_PABT;
        else if (req_undef) kind = EXC_UNDEF;
        else if (req_svc)   kind = EXC_SVC;
        else                kind = EXC_NONE;
    end

endmodule

// File: rtl/exc_status_gen.sv
// Builds the status word loaded on entry: new mode, raised masks, rest kept.
// Assumes the mode field occupies bits [MODE_W-1:0].
module exc_status_gen
    import exc_pkg::*;
#(
    parameter int STATUS_W     = 32,
    parameter int IRQ_MASK_BIT = 7,
    parameter int FIQ_MASK_BIT = 6
) (
    input  logic [STATUS_W-1:0] cur_status,
    input  exc_kind_e           kind,
    output logic [STATUS_W-1:0] next_status
);

    // Replace the mode field and raise the mask bits the cause calls for.
    always_comb begin
        next_status               = cur_status;
        next_status[MODE_W-1:0]   = mode_code(kind);
        next_status[IRQ_MASK_BIT] = 1'b1;
        if (sets_fast_mask(kind))
            next_status[FIQ_MASK_BIT] = 1'b1;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller: picks the eligible cause and, in one cycle,
// produces the flush pulse, the vector, the new status and the bank strobes.
// Assumes the core writes back new_status on flush before the next entry.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int STATUS_W     = 32,
    parameter int IRQ_MASK_BIT = 7,
    parameter int FIQ_MASK_BIT = 6,
    parameter int VEC_SHIFT    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_reset,
    input  logic                 req_undef,
    input  logic                 req_svc,
    input  logic                 req_pabt,
    input  logic                 req_dabt,
    input  logic                 irq_lvl,
    input  logic                 fiq_lvl,
    input  logic [STATUS_W-1:0]  cur_status,
    input  logic [ADDR_W-1:0]    cur_pc,
    output logic                 flush,
    output logic [ADDR_W-1:0]    redirect_pc,
    output logic [STATUS_W-1:0]  new_status,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [ADDR_W-1:0]    link_data,
    output logic [STATUS_W-1:0]  saved_data
);

    exc_kind_e            kind;
    logic [STATUS_W-1:0]  status_nx;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [ADDR_W-1:0]    vec_addr;
    logic                 accept;

    exc_arbiter u_arb (
        .req_reset (req_reset),
        .req_undef (req_undef),
        .req_svc   (req_svc),
        .req_pabt  (req_pabt),
        .req_dabt  (req_dabt),
        .irq_ok    (irq_lvl & ~cur_status[IRQ_MASK_BIT]),
        .fiq_ok    (fiq_lvl & ~cur_status[FIQ_MASK_BIT]),
        .kind      (kind)
    );

    exc_status_gen #(
        .STATUS_W     (STATUS_W),
        .IRQ_MASK_BIT (IRQ_MASK_BIT),
        .FIQ_MASK_BIT (FIQ_MASK_BIT)
    ) u_stat (
        .cur_status  (cur_status),
        .kind        (kind),
        .next_status (status_nx)
    );

    // One-hot decode of the target bank, one comparator per bank.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_hit[g] = (bank_idx(kind) == BANK_IW'(g));
    end

    // Vector address from the table slot and the word spacing.
    assign vec_addr = ADDR_W'(vec_slot(kind)) << VEC_SHIFT;

    // An entry is accepted only outside the flush cycle of the previous one.
    assign accept = (kind != EXC_NONE) && !flush;

    // Register the entry results; flush and strobes are single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush       <= 1'b0;
            bank_we     <= '0;
            redirect_pc <= '0;
            new_status  <= '0;
            link_data   <= '0;
            saved_data  <= '0;
        end else if (accept) begin
            flush       <= 1'b1;
            bank_we     <= bank_hit;
            redirect_pc <= vec_addr;
            new_status  <= status_nx;
            link_data   <= cur_pc;
            saved_data  <= cur_status;
        end else begin
            flush       <= 1'b0;
            bank_we     <= '0;
        end
    end

    // R2: flush never lasts two cycles.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // R5: exactly one bank strobe with flush, none without it.
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> ($countones(bank_we) == 1));
    a_r5_quiet_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (bank_we == '0));

    // R7: every entry leaves the normal-interrupt mask raised.
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> new_status[IRQ_MASK_BIT]);

    // R4: the fast-interrupt bank goes with the last vector slot.
    a_r4_fast_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && bank_we[4]) |-> (redirect_pc == (ADDR_W'(7) << VEC_SHIFT)));

    // R8: a masked interrupt alone does not start an entry.
    a_r8_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && irq_lvl && cur_status[IRQ_MASK_BIT] && !fiq_lvl &&
         !(req_reset || req_undef || req_svc || req_pabt || req_dabt)) |=> !flush);

    // R6: a data abort captures the interrupted PC as return address.
    a_r6_link_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && req_dabt) |=> (flush && link_data == $past(cur_pc)));

endmodule

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_reset, req_undef, req_svc, req_pabt, req_dabt, irq_lvl, fiq_lvl;
    logic [31:0] cur_status, cur_pc;
    logic        flush;
    logic [31:0] redirect_pc, new_status, link_data, saved_data;
    logic [4:0]  bank_we;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .req_reset (req_reset), .req_undef (req_undef), .req_svc (req_svc),
        .req_pabt (req_pabt), .req_dabt (req_dabt),
        .irq_lvl (irq_lvl), .fiq_lvl (fiq_lvl),
        .cur_status (cur_status), .cur_pc (cur_pc),
        .flush (flush), .redirect_pc (redirect_pc), .new_status (new_status),
        .bank_we (bank_we), .link_data (link_data), .saved_data (saved_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Request vector order: {fiq, irq, dabt, pabt, svc, undef, reset}.
    task automatic set_req(input logic [6:0] r);
        {fiq_lvl, irq_lvl, req_dabt, req_pabt, req_svc, req_undef, req_reset} = r;
    endtask

    // One edge later, observed at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive a cause set, check the whole entry, then clear and let it settle.
    task automatic do_entry(input string tag, input logic [6:0] r,
                            input logic [31:0] st, input logic [31:0] pc,
                            input logic [31:0] ev, input logic [4:0] em,
                            input int eb, input bit fset);
        logic [31:0] exp_st;
        exp_st = (st & ~32'h1f) | {27'd0, em} | 32'h80 | (fset ? 32'h40 : 32'h0);
        cur_status = st;
        cur_pc     = pc;
        set_req(r);
        step();
        chk({tag, " flush R2"}, {31'd0, flush}, 32'd1);
        chk({tag, " vector R4"}, redirect_pc, ev);
        chk({tag, " bank R5"}, {27'd0, bank_we}, 32'd1 << eb);
        chk({tag, " status R5 R7"}, new_status, exp_st);
        chk({tag, " link R6"}, link_data, pc);
        chk({tag, " saved R6"}, saved_data, st);
        set_req(7'd0);
        step();
        chk({tag, " pulse end R2"}, {31'd0, flush}, 32'd0);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        set_req(7'h7f);
        cur_status = 32'h10;
        cur_pc     = 32'h1234;
        step();
        step();
        chk("R1 flush", {31'd0, flush}, 32'd0);
        chk("R1 bank_we", {27'd0, bank_we}, 32'd0);
        chk("R1 redirect", redirect_pc, 32'd0);
        chk("R1 status", new_status, 32'd0);
        set_req(7'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_each_cause();
        do_entry("reset",  7'b0000001, 32'h10, 32'h100, 32'h00, 5'b10011, 0, 1);
        do_entry("undef",  7'b0000010, 32'h10, 32'h104, 32'h04, 5'b11011, 2, 0);
        do_entry("svc",    7'b0000100, 32'h10, 32'h108, 32'h08, 5'b10011, 0, 0);
        do_entry("pabt",   7'b0001000, 32'h10, 32'h10c, 32'h0c, 5'b10111, 1, 0);
        do_entry("dabt",   7'b0010000, 32'h10, 32'h110, 32'h10, 5'b10111, 1, 0);
        do_entry("irq",    7'b0100000, 32'h10, 32'h114, 32'h18, 5'b10010, 3, 0);
        do_entry("fiq",    7'b1000000, 32'h10, 32'h118, 32'h1c, 5'b10001, 4, 1);
    endtask

    task automatic t_priority();
        do_entry("R3 all",     7'b1111111, 32'h10, 32'h200, 32'h00, 5'b10011, 0, 1);
        do_entry("R3 no rst",  7'b1111110, 32'h10, 32'h204, 32'h10, 5'b10111, 1, 0);
        do_entry("R3 no dabt", 7'b1101110, 32'h10, 32'h208, 32'h1c, 5'b10001, 4, 1);
        do_entry("R3 no fiq",  7'b0101110, 32'h10, 32'h20c, 32'h18, 5'b10010, 3, 0);
        do_entry("R3 no irq",  7'b0001110, 32'h10, 32'h210, 32'h0c, 5'b10111, 1, 0);
        do_entry("R10 undef+svc", 7'b0000110, 32'h10, 32'h214, 32'h04, 5'b11011, 2, 0);
    endtask

    task automatic t_preserve();
        do_entry("R7 keep bits", 7'b0000100, 32'hA000_0213, 32'h300, 32'h08, 5'b10011, 0, 0);
    endtask

    task automatic t_hold();
        cur_status = 32'h10;
        cur_pc     = 32'h400;
        set_req(7'b0000010);
        step();
        chk("R2 held 1st", {31'd0, flush}, 32'd1);
        step();
        chk("R2 held gap", {31'd0, flush}, 32'd0);
        step();
        chk("R2 held 2nd", {31'd0, flush}, 32'd1);
        set_req(7'd0);
        step();
        step();
    endtask

    task automatic t_irq_mask();
        cur_status = 32'h90;
        cur_pc     = 32'h500;
        set_req(7'b0100000);
        step();
        chk("R8 masked a", {31'd0, flush}, 32'd0);
        step();
        chk("R8 masked b", {31'd0, flush}, 32'd0);
        cur_status = 32'h10;
        step();
        chk("R8 unmasked flush", {31'd0, flush}, 32'd1);
        chk("R8 unmasked vector", redirect_pc, 32'h18);
        cur_status = new_status;
        step();
        chk("R8 after entry", {31'd0, flush}, 32'd0);
        step();
        chk("R8 remasked", {31'd0, flush}, 32'd0);
        set_req(7'd0);
        step();
    endtask

    task automatic t_fiq_mask();
        cur_status = 32'h50;
        cur_pc     = 32'h600;
        set_req(7'b1000000);
        step();
        chk("R9 fiq masked", {31'd0, flush}, 32'd0);
        set_req(7'd0);
        step();
        do_entry("R9 irq wins", 7'b1100000, 32'h50, 32'h604, 32'h18, 5'b10010, 3, 0);
    endtask

    initial begin
        set_req(7'd0);
        cur_status = 32'h10;
        cur_pc     = 32'h0;
        rst_n      = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_each_cause();
        t_priority();
        t_preserve();
        t_hold();
        t_irq_mask();
        t_fiq_mask();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule